// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Controller

This block runs address and data cycles of the enhanced parallel port protocol (version 1.9 handshake) on an 8-bit peripheral bus. The host side is a single request strobe with three qualifiers: direction, address-or-data select and the write byte. While a cycle is in flight the block holds a not-ready flag, and for reads it hands back the captured byte. On the peripheral side it drives the write-direction line, the two active-low strobes, the bus direction bit and the output byte, and it follows the peripheral's active-low wait line.

The handshake is strictly interlocked. A cycle does not begin until the wait line is seen low. A strobe ends only after the wait line rises. The cycle does not close until the wait line drops again. A control bit that forces the bus to input turns a requested write into a cycle that looks like a read on the bus, and no error is raised. The wait line is resynchronised with a two-flop chain, and every peripheral-side output comes from a register.

Top module: `epp_cycle_ctrl`

## Requirements
- R1: After reset, nwrite, ndatastb and naddrstb are 1, pdir is 1 (input), busy is 0, and pdata_out and rdata are 0.
- R2: A request taken while busy is 0 raises busy on the next clock edge. Busy stays 1 until the cycle completes. A request made while busy is 1 is ignored, so busy stays 0 once the current cycle is done.
- R3: If nwait is 1 when a request is taken, nwrite, pdir, ndatastb, naddrstb and pdata_out stay unchanged until nwait goes to 0.
- R4: For a write (rd_nwr=0, pcd=0), pdata_out equals the requested byte, pdir is 0 and nwrite is 0 at least one clock before the strobe goes low.
- R5: addr_sel=1 selects naddrstb and addr_sel=0 selects ndatastb. The other strobe stays 1, and the two strobes are never low together.
- R6: The strobe stays low until nwait is 1. It returns high exactly three clock edges after nwait rises (two synchroniser flops plus the decision), and busy is still 1 at that point. If nwait is already 1 when the strobe falls, the strobe is released after the same latency.
- R7: After the strobe is released, busy stays 1 and nwrite stays unchanged until nwait is 0. Busy falls exactly three clock edges after nwait falls, and at that point nwrite and pdir have returned to 1.
- R8: For a read (rd_nwr=1), nwrite and pdir are 1 while the strobe is low. rdata takes the pdata_in value present on the edge where the strobe is released, and keeps it until the next read.
- R9: A write requested with pcd=1 runs a read-shaped cycle: nwrite and pdir stay 1, pdata_out keeps its previous value, rdata is not changed, and the cycle completes normally.
- R10: pdata_out does not change while either strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request a cycle; taken when busy is 0 |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| addr_sel | input | 1 | 1 = address cycle, 0 = data cycle |
| wdata | input | 8 | Byte to write |
| pcd | input | 1 | Bus direction control bit; 1 forces input |
| busy | output | 1 | Host not-ready, high for the whole cycle |
| rdata | output | 8 | Byte captured by the last read |
| nwait | input | 1 | Peripheral wait, active low, asynchronous |
| pdata_in | input | 8 | Byte driven by the peripheral |
| pdata_out | output | 8 | Byte driven toward the peripheral |
| pdir | output | 1 | Bus direction, 1 = input, 0 = output |
| nwrite | output | 1 | 0 = write cycle, 1 = read cycle |
| ndatastb | output | 1 | Data strobe, active low |
| naddrstb | output | 1 | Address strobe, active low |

## Verification
Capturing the read byte and releasing the strobe happen on the same clock edge. A late capture would take a byte that is already invalid. The bench drives a valid byte while the strobe is low and replaces it with its complement as soon as it sees the strobe high, so only a capture on the release edge returns the expected byte. A second coincidence is a new request arriving while a cycle is still in flight. The bench pulses a request with other qualifiers during the strobe phase and checks that the running cycle keeps its own fields and that busy stays low afterwards.

// File: rtl/epp_pkg.sv
package epp_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_SETUP,
    ST_STROBE,
    ST_TERM
  } epp_state_e;

  typedef struct packed {
    logic bus_read;   // bus sees a read (requested read, or write blocked by pcd)
    logic addr;       // address strobe selected
    logic true_read;  // host asked for a read; result is returned
  } epp_op_t;

  function automatic epp_op_t make_op(input logic rd_nwr, input logic addr_sel,
                                      input logic pcd);
    epp_op_t op;
    op.bus_read  = rd_nwr | pcd;
    op.addr      = addr_sel;
    op.true_read = rd_nwr;
    return op;
  endfunction
endpackage

// File: rtl/epp_sync.sv
module epp_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= RESET_VAL;
        else        chain <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/epp_fsm.sv
module epp_fsm
  import epp_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req,
  input  epp_op_t op_in,
  input  logic    wait_s,
  output logic    busy,
  output logic    nwrite,
  output logic    pdir,
  output logic    ndatastb,
  output logic    naddrstb,
  output logic    ev_accept,
  output logic    ev_setup,
  output logic    ev_release,
  output logic    ev_finish,
  output epp_op_t op_q
);
  epp_state_e state;

  assign ev_accept  = (state == ST_IDLE)   && req;
  assign ev_setup   = (state == ST_ARM)    && !wait_s;
  assign ev_release = (state == ST_STROBE) && wait_s;
  assign ev_finish  = (state == ST_TERM)   && !wait_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      busy     <= 1'b0;
      nwrite   <= 1'b1;
      pdir     <= 1'b1;
      ndatastb <= 1'b1;
      naddrstb <= 1'b1;
      op_q     <= '0;
    end else begin
      case (state)
        ST_IDLE: if (ev_accept) begin
          op_q  <= op_in;
          busy  <= 1'b1;
          state <= ST_ARM;
        end
        ST_ARM: if (ev_setup) begin
          nwrite <= op_q.bus_read;
          pdir   <= op_q.bus_read;
          state  <= ST_SETUP;
        end
        ST_SETUP: begin
          ndatastb <= op_q.addr;
          naddrstb <= !op_q.addr;
          state    <= ST_STROBE;
        end
        ST_STROBE: if (ev_release) begin
          ndatastb <= 1'b1;
          naddrstb <= 1'b1;
          state    <= ST_TERM;
        end
        ST_TERM: if (ev_finish) begin
          busy   <= 1'b0;
          nwrite <= 1'b1;
          pdir   <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/epp_datapath.sv
module epp_datapath
  import epp_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ev_accept,
  input  logic         ev_setup,
  input  logic         ev_release,
  input  epp_op_t      op_q,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pdata_in,
  output logic [W-1:0] pdata_out,
  output logic [W-1:0] rdata
);
  logic [W-1:0] wbuf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbuf      <= '0;
      pdata_out <= '0;
      rdata     <= '0;
    end else begin
      if (ev_accept)                      wbuf      <= wdata;
      if (ev_setup && !op_q.bus_read)     pdata_out <= wbuf;
      if (ev_release && op_q.true_read)   rdata     <= pdata_in;
    end
  end
endmodule

// File: rtl/epp_cycle_ctrl.sv
module epp_cycle_ctrl
  import epp_pkg::*;
#(
  parameter int W           = DATA_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req,
  input  logic         rd_nwr,
  input  logic         addr_sel,
  input  logic [W-1:0] wdata,
  input  logic         pcd,
  output logic         busy,
  output logic [W-1:0] rdata,
  input  logic         nwait,
  input  logic [W-1:0] pdata_in,
  output logic [W-1:0] pdata_out,
  output logic         pdir,
  output logic         nwrite,
  output logic         ndatastb,
  output logic         naddrstb
);
  logic    nwait_s;
  logic    ev_accept, ev_setup, ev_release, ev_finish;
  epp_op_t op_in, op_q;

  assign op_in = make_op(rd_nwr, addr_sel, pcd);

  epp_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(nwait), .q(nwait_s)
  );

  epp_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req(req), .op_in(op_in), .wait_s(nwait_s),
    .busy(busy), .nwrite(nwrite), .pdir(pdir), .ndatastb(ndatastb),
    .naddrstb(naddrstb), .ev_accept(ev_accept), .ev_setup(ev_setup),
    .ev_release(ev_release), .ev_finish(ev_finish), .op_q(op_q)
  );

  epp_datapath #(.W(W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ev_accept(ev_accept), .ev_setup(ev_setup),
    .ev_release(ev_release), .op_q(op_q), .wdata(wdata), .pdata_in(pdata_in),
    .pdata_out(pdata_out), .rdata(rdata)
  );
endmodule

// File: rtl/epp_cycle_ctrl_chk.sv
module epp_cycle_ctrl_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic         nwrite,
  input logic         pdir,
  input logic         ndatastb,
  input logic         naddrstb,
  input logic [W-1:0] pdata_out,
  input logic         nwait_s
);
  logic stb_low;
  assign stb_low = !ndatastb || !naddrstb;

  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ndatastb && !naddrstb));

  a_r4_setup_first: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ndatastb) || $fell(naddrstb)) |-> ($stable(nwrite) && $stable(pdir) && $stable(pdata_out)));

  a_r6_release_on_wait: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ndatastb) || $rose(naddrstb)) |-> $past(nwait_s));

  a_r6_busy_under_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    stb_low |-> busy);

  a_r7_finish_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!$past(nwait_s) && ndatastb && naddrstb && nwrite && pdir));

  a_r3_moves_need_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(nwrite) || !$stable(pdir)) |-> !$past(nwait_s));

  a_r10_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_low && $past(stb_low)) |-> $stable(pdata_out));
endmodule

bind epp_cycle_ctrl epp_cycle_ctrl_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .nwrite(nwrite), .pdir(pdir),
  .ndatastb(ndatastb), .naddrstb(naddrstb), .pdata_out(pdata_out),
  .nwait_s(nwait_s)
);

// File: tb/epp_cycle_ctrl_bench.sv
module epp_cycle_ctrl_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0, req = 1'b0, rd_nwr = 1'b0, addr_sel = 1'b0, pcd = 1'b0;
  logic [7:0] wdata = '0, pdata_in = '0;
  logic       nwait = 1'b1;
  logic       busy, pdir, nwrite, ndatastb, naddrstb;
  logic [7:0] rdata, pdata_out;

  epp_cycle_ctrl u_epp_cycle_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .rd_nwr(rd_nwr), .addr_sel(addr_sel),
    .wdata(wdata), .pcd(pcd), .busy(busy), .rdata(rdata), .nwait(nwait),
    .pdata_in(pdata_in), .pdata_out(pdata_out), .pdir(pdir), .nwrite(nwrite),
    .ndatastb(ndatastb), .naddrstb(naddrstb)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  logic [7:0] exp_rdata = '0, last_pdata = '0;

  function automatic logic exp_bus_read(input logic rd, input logic pc);
    return rd | pc;
  endfunction
  function automatic logic exp_rdata_loads(input logic rd);
    return rd;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input bit rd, input bit ad, input bit pc, input bit pre_hi,
                     input int k_pre, input int d_set, input int d_term,
                     input logic [7:0] wd, input logic [7:0] rb, input bit extra);
    bit ok; int n; logic prev_nw, prev_pdir, seen_nw;
    logic [7:0] seen_data; logic seen_a, seen_d;
    @(negedge clk);
    nwait = pre_hi;
    repeat (3) @(negedge clk);
    req = 1; rd_nwr = rd; addr_sel = ad; pcd = pc; wdata = wd;
    @(negedge clk);
    req = 0; rd_nwr = ~rd; addr_sel = ~ad; pcd = ~pc; wdata = ~wd;
    chk(busy == 1'b1, "R2 busy after request", busy, 1);
    if (pre_hi) begin
      ok = 1;
      repeat (k_pre) begin
        @(negedge clk);
        if (!(nwrite && pdir && ndatastb && naddrstb && pdata_out == last_pdata)) ok = 0;
      end
      chk(ok, "R3 outputs still while nwait high", ok, 1);
      nwait = 0;
    end
    n = 0; prev_nw = nwrite; prev_pdir = pdir;
    while (ndatastb && naddrstb && n < 50) begin
      prev_nw = nwrite; prev_pdir = pdir;
      @(negedge clk); n++;
    end
    seen_a = !naddrstb; seen_d = !ndatastb; seen_nw = nwrite; seen_data = pdata_out;
    pdata_in = rb;
    chk(n < 50, "R4 strobe started", n, 0);
    chk(seen_a == ad && seen_d == !ad, "R5 strobe select", {seen_a, seen_d}, {ad, !ad});
    chk(prev_nw == exp_bus_read(rd, pc) && prev_pdir == exp_bus_read(rd, pc),
        "R4 direction set before strobe", {prev_nw, prev_pdir}, {2{exp_bus_read(rd, pc)}});
    if (rd) chk(seen_nw && pdir, "R8 read levels", {seen_nw, pdir}, 2'b11);
    else if (pc) chk(seen_nw && pdir && seen_data == last_pdata, "R9 blocked write levels",
                     seen_data, last_pdata);
    else chk(seen_data == wd, "R4 write byte", seen_data, wd);
    if (d_set == 0) nwait = 1;
    else begin
      ok = 1;
      if (extra) begin
        req = 1; rd_nwr = 1; addr_sel = ~ad; pcd = 1;
        @(negedge clk);
        req = 0;
        if (ndatastb && naddrstb) ok = 0;
      end
      repeat (d_set) begin
        @(negedge clk);
        if (ndatastb && naddrstb) ok = 0;
        if (pdata_out != seen_data) ok = 0;
      end
      chk(ok, "R6 strobe held low, R10 data stable", ok, 1);
      nwait = 1;
    end
    n = 0;
    while (!(ndatastb && naddrstb) && n < 20) begin @(negedge clk); n++; end
    chk(n == 3, "R6 release latency", n, 3);
    chk(busy == 1'b1, "R6 busy at release", busy, 1);
    pdata_in = ~rb;
    ok = 1;
    repeat (d_term) begin
      @(negedge clk);
      if (!busy || nwrite != seen_nw) ok = 0;
    end
    chk(ok, "R7 hold until nwait low", ok, 1);
    nwait = 0;
    n = 0;
    while (busy && n < 20) begin @(negedge clk); n++; end
    chk(n == 3, "R7 finish latency", n, 3);
    chk(nwrite && pdir, "R7 idle levels", {nwrite, pdir}, 2'b11);
    if (exp_rdata_loads(rd)) exp_rdata = rb;
    if (!rd && pc) chk(rdata == exp_rdata, "R9 rdata untouched", rdata, exp_rdata);
    else chk(rdata == exp_rdata, "R8 rdata", rdata, exp_rdata);
    if (!rd && !pc) last_pdata = wd;
    if (extra) begin
      ok = 1;
      repeat (4) begin @(negedge clk); if (busy) ok = 0; end
      chk(ok, "R2 request during cycle ignored", busy, 0);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(nwrite && ndatastb && naddrstb && pdir && !busy && pdata_out == 0 && rdata == 0,
        "R1 reset state", {nwrite, ndatastb, naddrstb, pdir, busy}, 5'b11110);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(nwrite && ndatastb && naddrstb && pdir && !busy, "R1 after release",
        {nwrite, ndatastb, naddrstb, pdir, busy}, 5'b11110);
    run(0, 0, 0, 0, 0, 2, 2, 8'hA5, 8'h00, 0);
    run(0, 1, 0, 1, 4, 3, 1, 8'h3C, 8'h00, 0);
    run(1, 0, 0, 0, 0, 1, 2, 8'h00, 8'h96, 0);
    run(1, 1, 0, 1, 6, 0, 0, 8'h00, 8'h5A, 0);
    run(0, 0, 1, 0, 0, 2, 1, 8'hFF, 8'h11, 0);
    run(0, 1, 0, 0, 0, 0, 3, 8'hC3, 8'h00, 0);
    run(1, 0, 0, 0, 0, 3, 1, 8'h00, 8'h7E, 1);
    run(0, 0, 0, 1, 2, 4, 0, 8'h81, 8'h00, 1);
    for (int i = 0; i < 40; i++) begin
      run($urandom_range(0, 1), $urandom_range(0, 1), ($urandom_range(0, 3) == 0),
          $urandom_range(0, 1), $urandom_range(1, 6), $urandom_range(0, 4),
          $urandom_range(0, 3), 8'($urandom), 8'($urandom), 0);
    end
    finish_run();
  end
endmodule